// File: doc/BRIEF.md
# Mirrored Memory Chip-Select Decoder

This block is the purely combinational glue between the address and control lines of an 8-bit processor and the memory devices of a small home computer. From the second-highest address bit and the active-low memory-request, refresh and bus-acknowledge strobes it produces active-low selects for a 16 KiB ROM, a 16 KiB expansion SRAM and the original on-board RAM. It also forwards the memory-request strobe to the mainboard, where video circuitry latches data on its edges. That forwarded strobe floats whenever the processor has handed the bus to another master.

The top address bit plays no part in the decode. Each device therefore answers in both halves of the address space. Video hardware on the mainboard relies on the top address bit to recognise display fetches, and those fetches must still reach the RAM. The ROM sits in every quarter where the bank bit is 0, and the expansion RAM sits in every quarter where it is 1, so the two devices can never drive the data bus together. A strap input lets refresh cycles select the RAM as well, which is needed for high-resolution display tricks. With the expansion fitted, the on-board RAM select is held inactive.

Top module: `mirrored_memsel`

## Requirements
- R1: With mreq_n low, rom_cs_n is low exactly when addr[14] is 0. This holds in both address halves, 0x0000–0x3FFF and 0x8000–0xBFFF.
- R2: With mreq_n low, rfsh_n high and addr[14] at 1, xram_cs_n is low. This holds in both address halves, 0x4000–0x7FFF and 0xC000–0xFFFF.
- R3: At most one of rom_cs_n, xram_cs_n and obram_cs_n is low at any time. The RAM is never selected at an address where the ROM answers.
- R4: While mreq_n is high, rom_cs_n, xram_cs_n and obram_cs_n are all high.
- R5: With the expansion fitted (the default), obram_cs_n stays high for every input combination.
- R6: With hires_en at 0, a refresh cycle (mreq_n low, rfsh_n low) leaves xram_cs_n high. The ROM select still follows R1 during that cycle.
- R7: With hires_en at 1, a refresh cycle with addr[14] at 1 drives xram_cs_n low.
- R8: While busak_n is low, mreq_board_n is high-impedance.
- R9: While busak_n is high, mreq_board_n equals mreq_n, both low and high.
- R10: Every output settles in the same cycle as the input change that causes it. No output is registered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| addr | input | 16 | Processor address bus |
| mreq_n | input | 1 | Memory request strobe, active low |
| rfsh_n | input | 1 | Refresh cycle indicator, active low |
| busak_n | input | 1 | Bus acknowledge, active low: the processor has released the bus |
| hires_en | input | 1 | Strap, active high: refresh cycles may select the expansion RAM |
| rom_cs_n | output | 1 | ROM chip select, active low |
| xram_cs_n | output | 1 | Expansion SRAM chip select, active low |
| obram_cs_n | output | 1 | On-board RAM chip select, active low |
| mreq_board_n | output | 1 | Forwarded memory request to the mainboard; high-impedance while the bus is granted |

## Verification
Every result is combinational, so each output is due in the same cycle as the stimulus that causes it, with zero register stages. The bench changes the inputs just after a falling clock edge. It compares all outputs against its behavioural model shortly before the next rising edge, once the paths have settled and before any new stimulus arrives. Each cycle type (instruction fetch, data read, refresh with and without the strap, idle, bus released) is swept across the address space. In every sampled cycle the bench checks each select, the exclusivity of the selects and the level of the forwarded strobe. The high-impedance state is included in that strobe check.

// File: rtl/mem_dec_pkg.sv
package mem_dec_pkg;

   // Which device an address belongs to, before any strobe is applied
   typedef enum logic [1:0] {
      REG_ROM  = 2'd0,
      REG_XRAM = 2'd1,
      REG_NONE = 2'd2
   } region_t;

   // Active-low select bundle
   typedef struct packed {
      logic rom_n;
      logic xram_n;
      logic obram_n;
   } sel_bus_t;

   localparam int unsigned SEL_COUNT = 3;

endpackage

// File: rtl/mem_dec_region.sv
module mem_dec_region
   import mem_dec_pkg::*;
#(
   parameter int unsigned ADDR_W    = 16,
   parameter bit          MIRROR_EN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   output region_t           region
);

   localparam int unsigned BANK_BIT = ADDR_W - 2;
   localparam int unsigned TOP_BIT  = ADDR_W - 1;

   generate
      if (ADDR_W < 2) begin : g_bad_width
         $error("mem_dec_region: ADDR_W must be at least 2");
      end

      if (MIRROR_EN) begin : g_mirror
         // Top bit ignored: both halves map the same way
         always_comb begin
            if (addr[BANK_BIT]) region = REG_XRAM;
            else                region = REG_ROM;
         end
      end else begin : g_flat
         // Upper half left unmapped
         always_comb begin
            if (addr[TOP_BIT])       region = REG_NONE;
            else if (addr[BANK_BIT]) region = REG_XRAM;
            else                     region = REG_ROM;
         end
      end
   endgenerate

endmodule

// File: rtl/mem_dec_select.sv
module mem_dec_select
   import mem_dec_pkg::*;
#(
   parameter bit EXP_FITTED = 1'b1
) (
   input  region_t  region,
   input  logic     mreq_n,
   input  logic     rfsh_n,
   input  logic     hires_en,
   output sel_bus_t sel
);

   logic mem_active;
   logic ram_cycle_ok;

   assign mem_active   = ~mreq_n;
   // Refresh cycles reach the RAM only when the strap allows it
   assign ram_cycle_ok = rfsh_n | hires_en;

   always_comb begin
      sel.rom_n  = ~(mem_active && (region == REG_ROM));
      sel.xram_n = ~(mem_active && ram_cycle_ok && (region == REG_XRAM));
   end

   generate
      if (EXP_FITTED) begin : g_obram_off
         assign sel.obram_n = 1'b1;
      end else begin : g_obram_on
         assign sel.obram_n = ~(mem_active && (region == REG_XRAM));
      end
   endgenerate

   // R4: no select without a memory request
   always_comb begin
      p_mreq_gate_r4 : assert (!(mreq_n && (!sel.rom_n || !sel.xram_n || !sel.obram_n)))
         else $error("select asserted while mreq_n is high");
   end

   // R6: refresh without the strap leaves the expansion RAM alone
   always_comb begin
      p_refresh_block_r6 : assert (!(!rfsh_n && !hires_en && !sel.xram_n))
         else $error("expansion RAM selected during refresh without strap");
   end

endmodule

// File: rtl/mem_dec_mreq_drv.sv
module mem_dec_mreq_drv (
   input  logic mreq_n,
   input  logic busak_n,
   output logic mreq_board_n
);

   assign mreq_board_n = busak_n ? mreq_n : 1'bz;

   // R9: while the bus is held, the mainboard sees the raw strobe
   always_comb begin
      p_pass_through_r9 : assert (!(busak_n && (mreq_board_n !== mreq_n)))
         else $error("forwarded strobe differs from processor strobe");
   end

endmodule

// File: rtl/mirrored_memsel.sv
module mirrored_memsel
   import mem_dec_pkg::*;
#(
   parameter int unsigned ADDR_W     = 16,
   parameter bit          MIRROR_EN  = 1'b1,
   parameter bit          EXP_FITTED = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              mreq_n,
   input  logic              rfsh_n,
   input  logic              busak_n,
   input  logic              hires_en,
   output logic              rom_cs_n,
   output logic              xram_cs_n,
   output logic              obram_cs_n,
   output logic              mreq_board_n
);

   region_t  region;
   sel_bus_t sel;

   mem_dec_region #(
      .ADDR_W    (ADDR_W),
      .MIRROR_EN (MIRROR_EN)
   ) u_region (
      .addr   (addr),
      .region (region)
   );

   mem_dec_select #(
      .EXP_FITTED (EXP_FITTED)
   ) u_select (
      .region   (region),
      .mreq_n   (mreq_n),
      .rfsh_n   (rfsh_n),
      .hires_en (hires_en),
      .sel      (sel)
   );

   mem_dec_mreq_drv u_mreq_drv (
      .mreq_n       (mreq_n),
      .busak_n      (busak_n),
      .mreq_board_n (mreq_board_n)
   );

   assign rom_cs_n   = sel.rom_n;
   assign xram_cs_n  = sel.xram_n;
   assign obram_cs_n = sel.obram_n;

   // R3: never two devices on the data bus
   always_comb begin
      p_exclusive_r3 : assert ($countones({~rom_cs_n, ~xram_cs_n, ~obram_cs_n}) <= SEL_COUNT - 2)
         else $error("more than one memory select active");
   end

   // R5: on-board RAM stays disabled when the expansion is present
   generate
      if (EXP_FITTED) begin : g_chk_obram
         always_comb begin
            p_onboard_off_r5 : assert (obram_cs_n)
               else $error("on-board RAM selected with expansion fitted");
         end
      end
   endgenerate

endmodule

// File: tb/mirrored_memsel_tb.sv
module mirrored_memsel_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = 16'h0000;
   logic        mreq_n = 1'b1;
   logic        rfsh_n = 1'b1;
   logic        busak_n = 1'b1;
   logic        hires_en = 1'b0;
   wire         rom_cs_n;
   wire         xram_cs_n;
   wire         obram_cs_n;
   wire         mreq_board_n;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mirrored_memsel u_dut (
      .addr         (addr),
      .mreq_n       (mreq_n),
      .rfsh_n       (rfsh_n),
      .busak_n      (busak_n),
      .hires_en     (hires_en),
      .rom_cs_n     (rom_cs_n),
      .xram_cs_n    (xram_cs_n),
      .obram_cs_n   (obram_cs_n),
      .mreq_board_n (mreq_board_n)
   );

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 200000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected below 200000", cycles);
         finish_run();
      end
   end

   task automatic check_bit(string tag, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s addr=%h: actual %b expected %b", tag, what, addr, act, exp);
      end
   endtask

   // Behavioural reference, evaluated once the inputs have settled
   task automatic compare();
      bit   bank;
      logic e_rom, e_xram, e_ob, e_board;
      int   active;
      bank    = addr[14];
      e_rom   = !(!mreq_n && !bank);
      e_xram  = !(!mreq_n && bank && (rfsh_n || hires_en));
      e_ob    = 1'b1;
      e_board = busak_n ? mreq_n : 1'bz;
      check_bit(mreq_n ? "R4" : "R1", "rom_cs_n", rom_cs_n, e_rom);
      check_bit(mreq_n ? "R4" : (!rfsh_n ? (hires_en ? "R7" : "R6") : "R2"),
                "xram_cs_n", xram_cs_n, e_xram);
      check_bit("R5", "obram_cs_n", obram_cs_n, e_ob);
      check_bit(busak_n ? "R9" : "R8", "mreq_board_n", mreq_board_n, e_board);
      active = 0;
      if (rom_cs_n === 1'b0) active++;
      if (xram_cs_n === 1'b0) active++;
      if (obram_cs_n === 1'b0) active++;
      checks++;
      if (active > 1) begin
         errors++;
         $display("FAIL R3 exclusivity addr=%h: actual %0d selects expected at most 1", addr, active);
      end
   endtask

   // Drive after the falling edge, sample before the rising edge (R10: zero latency)
   task automatic apply(logic [15:0] a, logic m, logic r, logic b, logic h);
      @(negedge clk);
      addr     = a;
      mreq_n   = m;
      rfsh_n   = r;
      busak_n  = b;
      hires_en = h;
      #8;
      compare();
   endtask

   task automatic sweep(int stride, logic m, logic r, logic b, logic h);
      for (int a = 0; a < 65536; a += stride) begin
         apply(a[15:0], m, r, b, h);
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // Reset / idle state: R4 all selects inactive
      @(negedge clk);
      #8;
      compare();
      // Fetch: full sweep (R1, R2, R3)
      sweep(1, 1'b0, 1'b1, 1'b1, 1'b0);
      // Data read with strap set: no effect on normal cycles
      sweep(3, 1'b0, 1'b1, 1'b1, 1'b1);
      // Refresh without strap (R6)
      sweep(5, 1'b0, 1'b0, 1'b1, 1'b0);
      // Refresh with strap (R7)
      sweep(5, 1'b0, 1'b0, 1'b1, 1'b1);
      // Idle strobe (R4, R9 high level)
      sweep(7, 1'b1, 1'b1, 1'b1, 1'b0);
      // Bus released, strobe low and high (R8)
      sweep(11, 1'b0, 1'b1, 1'b0, 1'b0);
      sweep(13, 1'b1, 1'b1, 1'b0, 1'b1);
      // Mirror boundary corners (R1, R2)
      apply(16'h3FFF, 1'b0, 1'b1, 1'b1, 1'b0);
      apply(16'h4000, 1'b0, 1'b1, 1'b1, 1'b0);
      apply(16'h7FFF, 1'b0, 1'b1, 1'b1, 1'b0);
      apply(16'h8000, 1'b0, 1'b1, 1'b1, 1'b0);
      apply(16'hBFFF, 1'b0, 1'b1, 1'b1, 1'b0);
      apply(16'hC000, 1'b0, 1'b1, 1'b1, 1'b0);
      apply(16'hFFFF, 1'b0, 1'b0, 1'b1, 1'b1);
      // Strobe toggling on one address (R9, R4)
      apply(16'hC123, 1'b1, 1'b1, 1'b1, 1'b0);
      apply(16'hC123, 1'b0, 1'b1, 1'b1, 1'b0);
      apply(16'hC123, 1'b1, 1'b1, 1'b1, 1'b0);
      finish_run();
   end

endmodule